// File: doc/BRIEF.md
# Interleaved SAR Conversion Sequencer

This block is the digital controller for a bank of successive-approximation converter sections that work in parallel, each starting a new conversion one clock after its neighbour. There is one free-running phase counter. From it the block derives a frame step for every section and decodes six strobe vectors, each one bit per section: reference-zero sample, offset (auto-zero) compare, gain (auto-calibrate) compare, input sample, bit trial and transfer. Because the sections are staggered by one clock and the frame is as long as the number of sections, exactly one section samples the analog input on every clock.

Each section holds a successive-approximation register. The register is loaded with its top trial bit when the section samples. On every trial clock it keeps or drops the bit under test, using that section's comparator decision, and raises the next lower bit. On its transfer step the section's finished code goes out through one shared result port, tagged with the section number. A power-up timer holds a calibration-ready flag low until enough clocks have passed for the background calibration loops to settle. The analog parts (track-and-hold, DAC, comparators, calibration integrators and reference ladder) are outside the block. The comparator of each section appears only as one input bit.

Top module: `sar_seq_top`

## Requirements
- R1: On every clock exactly one bit of `smp_stb` is high.
- R2: Each section runs a frame of SAR_W+5 steps, with exactly one of its six strobes high per clock. The steps are step 0 reference-zero (`rz_stb`), step 1 auto-zero (`az_stb`), step 2 auto-calibrate (`ac_stb`), step 3 input sample (`smp_stb`), steps 4 to SAR_W+3 bit trials (`trial_stb`), and the last step transfer (`xfer_stb`). Section k is at step (P − k) mod 18, where P counts the clock edges since reset was released.
- R3: Section k+1 (mod 18) is at the step section k was at one clock earlier. With the defaults, section (P − 3) mod 18 is the one that samples.
- R4: The complete strobe pattern repeats every 18 clocks.
- R5: The clock edge that ends a section's sample step loads its register (`sar_code[k*SAR_W +: SAR_W]`) with only the top bit set.
- R6: Trial j (j = 0 is the first trial) tests bit SAR_W−1−j, so the most significant bit is tested first. While trial j is in progress, the register shows the bits already decided above the tested bit, the tested bit set, and zeros below it. The edge that ends trial j writes `cmp_bit[k]` into the tested bit (1 keeps it, 0 clears it) and sets the next lower bit, if there is one.
- R7: `cmp_bit[k]` has no effect outside section k's trial steps. During the reference-zero, auto-zero and auto-calibrate steps the register still holds the previous finished code.
- R8: While section k is at its transfer step, `res_sec` equals k and `res_data` equals section k's finished code.
- R9: `res_valid` is high on a section's transfer step only if that section has passed through a sample step since reset was released.
- R10: `cal_ready` is low for the first CAL_CYCLES edges after reset is released. From edge CAL_CYCLES onward it is high and stays high.
- R11: While `rst_n` is low (synchronous, active low), section 0 is at step 0 (so `rz_stb` = 1 and `smp_stb` = bit 15), every register reads zero, `res_valid` and `cal_ready` are low, and the calibration count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_bit | input | 18 | Comparator decision per section, 1 = keep the trial bit |
| rz_stb | output | 18 | Reference-zero sample strobe per section |
| az_stb | output | 18 | Auto-zero compare strobe per section |
| ac_stb | output | 18 | Auto-calibrate compare strobe per section |
| smp_stb | output | 18 | Input sample strobe per section, one-hot |
| trial_stb | output | 18 | Bit-trial strobe per section |
| xfer_stb | output | 18 | Transfer strobe per section |
| sar_code | output | 234 | Register of each section, section k at bits k*13 +: 13, feeds that section's DAC |
| res_data | output | 13 | Finished code of the section now transferring |
| res_sec | output | 5 | Number of the section now transferring |
| res_valid | output | 1 | The transferring section holds a genuine conversion |
| cal_ready | output | 1 | Power-up calibration interval has elapsed |

## Verification
If the phase counter or the per-section step decode is wrong, it shows at once: a strobe vector loses its one-hot sample bit or fires in the wrong section on the very next clock. If a section's register decides a bit wrongly, `sar_code` shows it in the next trial clock. The shared result port also shows it on that section's transfer step, at most 14 clocks after the bad decision. A wrong valid tag shows on the first transfer after reset. A fault in the calibration counter shows only around clock 10,000, so the bench runs past that edge and checks the flag on every clock.

// File: rtl/sar_seq_pkg.sv
// Shared step numbering and step classification for the interleaved
// SAR sequencer. Assumes the frame is laid out as three calibration
// steps, one sample step, the bit trials, then one transfer step.
package sar_seq_pkg;

    typedef enum logic [2:0] {
        SK_REFZ,
        SK_AZERO,
        SK_ACAL,
        SK_SAMPLE,
        SK_TRIAL,
        SK_XFER
    } step_kind_t;

    localparam int FIXED_STEPS = 5;
    localparam int STEP_REFZ   = 0;
    localparam int STEP_AZERO  = 1;
    localparam int STEP_ACAL   = 2;
    localparam int STEP_SAMPLE = 3;
    localparam int STEP_TRIAL0 = 4;

    // Map a frame step number to its kind for a frame with n_trials trials.
    function automatic step_kind_t kind_of(input int step, input int n_trials);
        if (step == STEP_REFZ)                       return SK_REFZ;
        else if (step == STEP_AZERO)                 return SK_AZERO;
        else if (step == STEP_ACAL)                  return SK_ACAL;
        else if (step == STEP_SAMPLE)                return SK_SAMPLE;
        else if (step < STEP_TRIAL0 + n_trials)      return SK_TRIAL;
        else                                         return SK_XFER;
    endfunction

endpackage

// File: rtl/phase_gen.sv
// Phase generator: one modulo-NUM_SEC counter. Each section's frame step
// is the counter minus the section index, taken modulo NUM_SEC, so
// neighbouring sections sit one clock apart. Decodes the six strobe
// vectors. Assumes NUM_SEC equals the frame length.
module phase_gen
    import sar_seq_pkg::*;
#(
    parameter int NUM_SEC = 18,
    parameter int STEP_W  = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [NUM_SEC-1:0][STEP_W-1:0]  sec_step,
    output logic [NUM_SEC-1:0]              rz_stb,
    output logic [NUM_SEC-1:0]              az_stb,
    output logic [NUM_SEC-1:0]              ac_stb,
    output logic [NUM_SEC-1:0]              smp_stb,
    output logic [NUM_SEC-1:0]              trial_stb,
    output logic [NUM_SEC-1:0]              xfer_stb
);

    localparam int                N_TRIALS = NUM_SEC - FIXED_STEPS;
    localparam logic [STEP_W-1:0] PH_LAST  = STEP_W'(NUM_SEC - 1);

    logic [STEP_W-1:0] ph_q;

    // Advance the shared phase, wrapping after the last frame step.
    always_ff @(posedge clk) begin
        if (!rst_n)               ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                      ph_q <= ph_q + 1'b1;
    end

    for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
        logic [STEP_W-1:0] st;
        step_kind_t        kd;

        if (k == 0) begin : g_first
            assign st = ph_q;
        end else begin : g_rest
            // Offset the shared phase by this section's index, modulo NUM_SEC.
            always_comb begin
                if (ph_q >= STEP_W'(k)) st = ph_q - STEP_W'(k);
                else                    st = ph_q + STEP_W'(NUM_SEC - k);
            end
        end

        assign kd           = kind_of(int'(st), N_TRIALS);
        assign sec_step[k]  = st;
        assign rz_stb[k]    = (kd == SK_REFZ);
        assign az_stb[k]    = (kd == SK_AZERO);
        assign ac_stb[k]    = (kd == SK_ACAL);
        assign smp_stb[k]   = (kd == SK_SAMPLE);
        assign trial_stb[k] = (kd == SK_TRIAL);
        assign xfer_stb[k]  = (kd == SK_XFER);

        // R2: frame order of the fixed steps within one section
        a_r2_rz_to_az: assert property (@(posedge clk) disable iff (!rst_n)
            rz_stb[k] |=> az_stb[k]);
        a_r2_az_to_ac: assert property (@(posedge clk) disable iff (!rst_n)
            az_stb[k] |=> ac_stb[k]);
        a_r2_ac_to_smp: assert property (@(posedge clk) disable iff (!rst_n)
            ac_stb[k] |=> smp_stb[k]);
        a_r2_smp_to_trial: assert property (@(posedge clk) disable iff (!rst_n)
            smp_stb[k] |=> trial_stb[k]);
        a_r2_xfer_to_rz: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_stb[k] |=> rz_stb[k]);
        a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
            $countones({rz_stb[k], az_stb[k], ac_stb[k], smp_stb[k],
                        trial_stb[k], xfer_stb[k]}) == 1);

        // R3: the sample strobe moves to the next section one clock later
        a_r3_stagger: assert property (@(posedge clk) disable iff (!rst_n)
            smp_stb[k] |=> smp_stb[(k + 1) % NUM_SEC]);
    end

    // R1: exactly one section samples per clock
    a_r1_one_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(smp_stb) == 1);

    // R4: phase wraps after NUM_SEC clocks
    a_r4_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_LAST) |=> (ph_q == '0));
    a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_LAST) |=> (ph_q == $past(ph_q) + 1'b1));

endmodule

// File: rtl/sar_section.sv
// One successive-approximation register. The sample step loads the top
// trial bit. Each trial step writes the comparator decision into the bit
// under test and raises the next lower bit. The register holds its value
// on every other step. Assumes the comparator decision is valid at the
// edge that ends the trial clock.
module sar_section
    import sar_seq_pkg::*;
#(
    parameter int SAR_W  = 13,
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step,
    input  logic              cmp,
    output logic [SAR_W-1:0]  code,
    output logic              xfer_valid
);

    localparam logic [SAR_W-1:0]  MSB_ONLY   = {1'b1, {(SAR_W-1){1'b0}}};
    localparam logic [STEP_W-1:0] FIRST_TRL  = STEP_W'(STEP_TRIAL0);
    localparam logic [STEP_W-1:0] LAST_TRL   = STEP_W'(STEP_TRIAL0 + SAR_W - 1);

    step_kind_t       kind;
    logic [SAR_W-1:0] code_q, code_d;
    logic             primed_q;
    int               tb;

    assign kind = kind_of(int'(step), SAR_W);

    // Next register value: load on sample, resolve one bit per trial.
    always_comb begin
        tb     = SAR_W - 1 - (int'(step) - STEP_TRIAL0);
        code_d = code_q;
        case (kind)
            SK_SAMPLE: code_d = MSB_ONLY;
            SK_TRIAL: begin
                for (int b = 0; b < SAR_W; b++) begin
                    if (b == tb)          code_d[b] = cmp;
                    else if (b == tb - 1) code_d[b] = 1'b1;
                end
            end
            default: code_d = code_q;
        endcase
    end

    // Register update and record of a sample taken since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            code_q <= code_d;
            if (kind == SK_SAMPLE) primed_q <= 1'b1;
        end
    end

    assign code       = code_q;
    assign xfer_valid = primed_q && (kind == SK_XFER);

    // R5: sample edge leaves only the top trial bit set
    a_r5_msb_load: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SK_SAMPLE) |=> (code_q == MSB_ONLY));

    // R6: first and last trials capture the comparator decision
    a_r6_first_decide: assert property (@(posedge clk) disable iff (!rst_n)
        (step == FIRST_TRL) |=> (code_q[SAR_W-1] == $past(cmp)));
    a_r6_last_decide: assert property (@(posedge clk) disable iff (!rst_n)
        (step == LAST_TRL) |=> (code_q[0] == $past(cmp)));

    // R7: register ignores the comparator outside trials
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind inside {SK_REFZ, SK_AZERO, SK_ACAL, SK_XFER}) |=> $stable(code_q));

endmodule

// File: rtl/cal_timer.sv
// Power-up calibration timer: counts clocks after reset is released and
// raises a sticky ready flag once CAL_CYCLES edges have passed.
module cal_timer #(
    parameter int CAL_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);

    localparam int               CNT_W = $clog2(CAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CAL_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Count up to the limit and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign ready = (cnt_q == LIMIT);

    // R10: flag never drops once set
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    // R10: counter advances by one each clock until ready
    a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/result_mux.sv
// Result selector: passes the code, index and valid tag of whichever
// section holds the transfer strobe. Assumes at most one transfer
// strobe is high.
module result_mux #(
    parameter int NUM_SEC = 18,
    parameter int SAR_W   = 13,
    parameter int SEC_W   = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SEC-1:0]             xfer_stb,
    input  logic [NUM_SEC-1:0][SAR_W-1:0]  codes,
    input  logic [NUM_SEC-1:0]             valids,
    output logic [SAR_W-1:0]               res_data,
    output logic [SEC_W-1:0]               res_sec,
    output logic                           res_valid
);

    // Select the transferring section.
    always_comb begin
        res_data  = '0;
        res_sec   = '0;
        res_valid = 1'b0;
        for (int k = 0; k < NUM_SEC; k++) begin
            if (xfer_stb[k]) begin
                res_data  = codes[k];
                res_sec   = SEC_W'(k);
                res_valid = valids[k];
            end
        end
    end

    // R8: exactly one section transfers per clock
    a_r8_single_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(xfer_stb) == 1);
    // R9: a valid tag only comes with a transfer strobe
    a_r9_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(valids & ~xfer_stb) && ((valids & ~xfer_stb) == '0));

endmodule

// File: rtl/sar_seq_top.sv
// Top of the interleaved SAR sequencer: phase generator, one register
// per section, result selector and power-up calibration timer. The frame
// length is tied to the register width, so the section count follows
// from SAR_W.
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter  int SAR_W      = 13,
    parameter  int CAL_CYCLES = 10000,
    localparam int NUM_SEC    = SAR_W + FIXED_STEPS,
    localparam int SEC_W      = $clog2(NUM_SEC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SEC-1:0]         cmp_bit,
    output logic [NUM_SEC-1:0]         rz_stb,
    output logic [NUM_SEC-1:0]         az_stb,
    output logic [NUM_SEC-1:0]         ac_stb,
    output logic [NUM_SEC-1:0]         smp_stb,
    output logic [NUM_SEC-1:0]         trial_stb,
    output logic [NUM_SEC-1:0]         xfer_stb,
    output logic [NUM_SEC*SAR_W-1:0]   sar_code,
    output logic [SAR_W-1:0]           res_data,
    output logic [SEC_W-1:0]           res_sec,
    output logic                       res_valid,
    output logic                       cal_ready
);

    localparam int STEP_W = SEC_W;

    logic [NUM_SEC-1:0][STEP_W-1:0] sec_step;
    logic [NUM_SEC-1:0][SAR_W-1:0]  codes;
    logic [NUM_SEC-1:0]             valids;

    phase_gen #(
        .NUM_SEC (NUM_SEC),
        .STEP_W  (STEP_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_step  (sec_step),
        .rz_stb    (rz_stb),
        .az_stb    (az_stb),
        .ac_stb    (ac_stb),
        .smp_stb   (smp_stb),
        .trial_stb (trial_stb),
        .xfer_stb  (xfer_stb)
    );

    for (genvar k = 0; k < NUM_SEC; k++) begin : g_sar
        sar_section #(
            .SAR_W  (SAR_W),
            .STEP_W (STEP_W)
        ) u_sec (
            .clk        (clk),
            .rst_n      (rst_n),
            .step       (sec_step[k]),
            .cmp        (cmp_bit[k]),
            .code       (codes[k]),
            .xfer_valid (valids[k])
        );
    end

    assign sar_code = codes;

    result_mux #(
        .NUM_SEC (NUM_SEC),
        .SAR_W   (SAR_W),
        .SEC_W   (SEC_W)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_stb  (xfer_stb),
        .codes     (codes),
        .valids    (valids),
        .res_data  (res_data),
        .res_sec   (res_sec),
        .res_valid (res_valid)
    );

    cal_timer #(
        .CAL_CYCLES (CAL_CYCLES)
    ) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (cal_ready)
    );

endmodule

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;

    localparam int W   = 13;
    localparam int NS  = 18;
    localparam int SW  = 5;
    localparam int CAL = 10000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NS-1:0]     cmp_bit;
    logic [NS-1:0]     rz_stb, az_stb, ac_stb, smp_stb, trial_stb, xfer_stb;
    logic [NS*W-1:0]   sar_code;
    logic [W-1:0]      res_data;
    logic [SW-1:0]     res_sec;
    logic              res_valid, cal_ready;

    int n_cmp = 0;
    int n_bad = 0;
    int c     = 0;
    int n_smp = 0;
    bit done  = 1'b0;
    bit              primed [NS];
    logic [W-1:0]    target [NS];
    logic [NS-1:0]   hist   [NS];

    sar_seq_top #(.SAR_W(W), .CAL_CYCLES(CAL)) i_sar_seq_top (
        .clk(clk), .rst_n(rst_n), .cmp_bit(cmp_bit),
        .rz_stb(rz_stb), .az_stb(az_stb), .ac_stb(ac_stb),
        .smp_stb(smp_stb), .trial_stb(trial_stb), .xfer_stb(xfer_stb),
        .sar_code(sar_code), .res_data(res_data), .res_sec(res_sec),
        .res_valid(res_valid), .cal_ready(cal_ready)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int step_of(input int ph, input int k);
        return (ph - k + NS) % NS;
    endfunction

    // 0 rz, 1 az, 2 ac, 3 sample, 4 trial, 5 transfer
    function automatic int kind_of_step(input int s);
        if (s <= 3)       return s;
        else if (s <= 16) return 4;
        else              return 5;
    endfunction

    // Register contents expected while trial j is in progress.
    function automatic logic [W-1:0] trial_code(input logic [W-1:0] t, input int j);
        logic [W-1:0] r;
        r = '0;
        for (int b = W - j; b < W; b++) r[b] = t[b];
        r[W-1-j] = 1'b1;
        return r;
    endfunction

    function automatic logic [W-1:0] pick_target(input int n);
        case (n % 6)
            0: return 13'h0000;
            1: return 13'h1FFF;
            2: return 13'h1000;
            3: return 13'h0001;
            4: return 13'h0AAA;
            default: return 13'h1555;
        endcase
    endfunction

    task automatic check_reset_state();
        chk("R11", "rz_stb in reset",  longint'(rz_stb),  longint'(1));
        chk("R11", "smp_stb in reset", longint'(smp_stb), longint'(1 << 15));
        chk("R11", "sar_code zero",    longint'(sar_code == '0), 1);
        chk("R11", "res_valid low",    longint'(res_valid), 0);
        chk("R11", "cal_ready low",    longint'(cal_ready), 0);
    endtask

    // Check all outputs for the current clock and drive the comparators.
    task automatic cycle();
        int ph;
        logic [NS-1:0] e_rz, e_az, e_ac, e_smp, e_tr, e_xf, drv;
        ph = c % NS;
        e_rz = '0; e_az = '0; e_ac = '0; e_smp = '0; e_tr = '0; e_xf = '0;
        drv = NS'($urandom);
        for (int k = 0; k < NS; k++) begin
            int s, kd;
            logic [W-1:0] code;
            s    = step_of(ph, k);
            kd   = kind_of_step(s);
            code = sar_code[k*W +: W];
            case (kd)
                0: e_rz[k] = 1'b1;
                1: e_az[k] = 1'b1;
                2: e_ac[k] = 1'b1;
                3: e_smp[k] = 1'b1;
                4: e_tr[k] = 1'b1;
                default: e_xf[k] = 1'b1;
            endcase
            if (kd <= 2 && primed[k])
                chk("R7", "code held across calibration steps", longint'(code), longint'(target[k]));
            if (kd == 3) begin
                target[k] = (n_smp < 18) ? pick_target(n_smp) : W'($urandom);
                n_smp++;
                primed[k] = 1'b1;
            end
            if (kd == 4) begin
                int j;
                j = s - 4;
                if (primed[k]) begin
                    if (j == 0) chk("R5", "msb loaded at sample", longint'(code), longint'(trial_code(target[k], 0)));
                    else        chk("R6", "trial register", longint'(code), longint'(trial_code(target[k], j)));
                    drv[k] = target[k][W-1-j];
                end
            end
            if (kd == 5) begin
                chk("R8", "res_sec", longint'(res_sec), longint'(k));
                chk("R9", "res_valid", longint'(res_valid), longint'(primed[k]));
                if (primed[k]) chk("R8", "res_data", longint'(res_data), longint'(target[k]));
            end
        end
        chk("R1", "one sample strobe", longint'($countones(smp_stb)), 1);
        chk("R3", "smp_stb position", longint'(smp_stb), longint'(e_smp));
        chk("R2", "rz_stb", longint'(rz_stb), longint'(e_rz));
        chk("R2", "az_stb", longint'(az_stb), longint'(e_az));
        chk("R2", "ac_stb", longint'(ac_stb), longint'(e_ac));
        chk("R2", "trial_stb", longint'(trial_stb), longint'(e_tr));
        chk("R2", "xfer_stb", longint'(xfer_stb), longint'(e_xf));
        if (c >= NS) chk("R4", "pattern repeats", longint'(smp_stb), longint'(hist[ph]));
        hist[ph] = smp_stb;
        chk("R10", "cal_ready", longint'(cal_ready), longint'(c >= CAL));
        cmp_bit = drv;
    endtask

    task automatic run(input int n);
        repeat (n) begin
            cycle();
            @(posedge clk);
            c++;
            @(negedge clk);
        end
    endtask

    task automatic start_after_reset();
        c = 0;
        for (int k = 0; k < NS; k++) primed[k] = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n   = 1'b0;
        cmp_bit = '0;
        for (int k = 0; k < NS; k++) begin
            primed[k] = 1'b0;
            target[k] = '0;
            hist[k]   = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        start_after_reset();
        run(400);
        // Reset mid-frame: state restarts, stale sections lose their valid tag.
        rst_n = 1'b0;
        cmp_bit = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        start_after_reset();
        run(CAL + 60);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule